// File: doc/BRIEF.md
# Loop Transmitter Configuration and Fault Controller

This block sits behind a single-wire frame receiver in a current-loop transmitter. Each decoded frame arrives as one write strobe carrying a destination flag, an 8-bit address and a 16-bit payload. A data frame carries a new converter code. A configuration frame carries an address and one data byte. The block keeps the converter code, an unlock key register, a self-clearing command register, a fault-enable register, a receive-error limit and two alarm codes. It then picks the 16-bit code that goes to the sigma-delta modulator.

Four fault sources are tracked: loop compliance (a level input stands in for the analog sensing), channel inactivity (a millisecond timer restarted by every valid symbol), parity errors and framing errors. A power-on error condition is also held until the first valid frame arrives. Any enabled fault pulls the active-low error flag. While a fault is present, the output code is replaced by an alarm code. A loop fault always selects the low alarm. The other sources select the high or the low alarm through a level-select pin. When the fault goes away, the output returns to the last accepted code.

Top module: `loop_cfg_fault`

## Requirements
- R1: After reset the error flag is low, the acknowledge enable is 1, the error limit is 8, and the output code is the low alarm default 0x2400 (3.375 mA on a 24 mA, 16-bit scale) when `alarm_hi_sel` is 0, or the high alarm default 0xE800 (21.75 mA) when it is 1.
- R2: Configuration writes to addresses 0x01 to 0x05 are ignored while the block is locked, which is its reset state. Writing 0x95 to address 0x00 unlocks it, and writing any other value to address 0x00 locks it.
- R3: A data frame loads the converter code only while the block is locked. A data frame is ignored while the block is unlocked.
- R4: The power-on error condition is cleared by any valid frame. A command write (address 0x01) with bits 4:3 = 01 sets it, and bits 4:3 = 10 clears it.
- R5: A command write with bit 0 set restores every register to its reset value, in the same way as a hardware reset. This includes the lock, the alarm codes, the converter code (0) and the power-on error.
- R6: In the enable register (address 0x02, reset 0x1F), bit 4 drives `ack_en`. Bits 3, 2, 1 and 0 enable reporting of framing, parity, channel and loop faults. A disabled source changes neither `err_n` nor the output code.
- R7: A channel fault is present once TIMEOUT_MS × CLK_PER_MS clock cycles have passed without `sym_ok`. It is absent again in the cycle after `sym_ok` is seen.
- R8: An enabled loop fault forces the low alarm code whatever `alarm_hi_sel` is. The fault clears itself after the timeout interval, and the normal code is then used again.
- R9: An enabled channel, parity or framing fault, or the power-on error, selects the high alarm when `alarm_hi_sel` is 1 and the low alarm when it is 0, and drives `err_n` low. Parity and framing faults are held until the next valid frame.
- R10: When every fault is gone, the output code returns to the last accepted converter code.
- R11: A write to address 0x04 (low alarm) or 0x05 (high alarm) shifts the data byte into the bottom of the 16-bit code, so a pair of writes loads the high byte first and then the low byte.
- R12: Address 0x03 holds a 4-bit error limit taken from data bits 3:0, with reset value 8. Writes to addresses above 0x05 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: a valid frame was received |
| frm_cfg | input | 1 | 1 = configuration frame, 0 = data frame |
| frm_addr | input | 8 | Register address (configuration frames) |
| frm_data | input | 16 | Payload; configuration frames use bits 7:0 |
| sym_ok | input | 1 | A valid symbol was received this cycle |
| par_err | input | 1 | Pulse: parity error detected in a frame |
| frm_err | input | 1 | Pulse: invalid symbol or wrong symbol count |
| loop_fault | input | 1 | Loop cannot sustain the requested current |
| alarm_hi_sel | input | 1 | Alarm band select: 1 = high, 0 = low |
| dac_code | output | 16 | Code sent to the modulator |
| err_n | output | 1 | Active-low error flag |
| ack_en | output | 1 | Acknowledge pulse enable for the receiver |
| rx_err_limit | output | 4 | Receive-error limit for the receiver |

## Verification
The bench goes after the lock and the data-path interplay. A design that inverted the lock polarity would let data frames through while configuration is open, or would accept configuration writes while it is closed. The channel timer is checked one cycle before and exactly at expiry, so an off-by-one prescaler or a comparison on the wrong count shows up directly. The alarm registers are loaded byte by byte and read back through the output in both bands, and a loop fault is raised with the high band selected. A design that swapped the byte order, or that let the band pin steer a loop fault, would drive the wrong code. Each enable bit is cleared in turn to show that a masked source stays silent, and the soft reset is checked to show that it puts back the lock and the power-on error.

// File: rtl/cfgflt_pkg.sv
package cfgflt_pkg;
  localparam int CODE_W = 16;
  localparam int FS_UA  = 24000;

  localparam logic [7:0] A_LOCK  = 8'h00;
  localparam logic [7:0] A_CMD   = 8'h01;
  localparam logic [7:0] A_MASK  = 8'h02;
  localparam logic [7:0] A_RXCNT = 8'h03;
  localparam logic [7:0] A_ALO   = 8'h04;
  localparam logic [7:0] A_AHI   = 8'h05;
  localparam logic [7:0] UNLOCK_KEY = 8'h95;

  localparam logic [4:0] MASK_RST  = 5'h1F;
  localparam logic [3:0] RXCNT_RST = 4'h8;

  // microamps to a full-scale code on the 24 mA range
  function automatic logic [CODE_W-1:0] ua_to_code(input longint ua);
    return CODE_W'((ua * (longint'(1) << CODE_W)) / FS_UA);
  endfunction

  // byte-pair loading: the new byte enters at the bottom
  function automatic logic [CODE_W-1:0] shift_byte(input logic [CODE_W-1:0] cur,
                                                   input logic [7:0] b);
    return {cur[CODE_W-9:0], b};
  endfunction

  localparam logic [CODE_W-1:0] ALO_RST = ua_to_code(3375);
  localparam logic [CODE_W-1:0] AHI_RST = ua_to_code(21750);
endpackage

// File: rtl/cfgflt_timer.sv
module cfgflt_timer #(
  parameter int CLK_PER_MS = 1000,
  parameter int TIMEOUT_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int MS_W  = $clog2(TIMEOUT_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(TIMEOUT_MS);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             ms_tick;

  assign ms_tick = (pre_q == PRE_LAST);
  assign expired = (ms_q == MS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (clr) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (run && !expired) begin
      pre_q <= ms_tick ? '0 : pre_q + 1'b1;
      if (ms_tick) ms_q <= ms_q + 1'b1;
    end
  end

  // R7: once expired, the timer stays expired until restarted
  assert_expiry_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/cfgflt_regs.sv
module cfgflt_regs
  import cfgflt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_cfg,
  input  logic [7:0]        frm_addr,
  input  logic [CODE_W-1:0] frm_data,
  output logic [CODE_W-1:0] dac_reg,
  output logic [CODE_W-1:0] alarm_lo,
  output logic [CODE_W-1:0] alarm_hi,
  output logic [4:0]        en_mask,
  output logic [3:0]        rx_limit,
  output logic              por_err,
  output logic              soft_rst
);
  logic       unlocked;
  logic       cfg_wr;
  logic       cmd_wr;
  logic       cmd_set;
  logic [7:0] wbyte;

  assign wbyte    = frm_data[7:0];
  assign cfg_wr   = frm_valid && frm_cfg && unlocked;
  assign cmd_wr   = cfg_wr && (frm_addr == A_CMD);
  assign cmd_set  = cmd_wr && (wbyte[4:3] == 2'b01);
  assign soft_rst = cmd_wr && wbyte[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      dac_reg  <= '0;
      alarm_lo <= ALO_RST;
      alarm_hi <= AHI_RST;
      en_mask  <= MASK_RST;
      rx_limit <= RXCNT_RST;
      por_err  <= 1'b1;
    end else if (soft_rst) begin
      unlocked <= 1'b0;
      dac_reg  <= '0;
      alarm_lo <= ALO_RST;
      alarm_hi <= AHI_RST;
      en_mask  <= MASK_RST;
      rx_limit <= RXCNT_RST;
      por_err  <= 1'b1;
    end else if (frm_valid) begin
      por_err <= cmd_set;
      if (!frm_cfg) begin
        if (!unlocked) dac_reg <= frm_data;
      end else if (frm_addr == A_LOCK) begin
        unlocked <= (wbyte == UNLOCK_KEY);
      end else if (unlocked) begin
        case (frm_addr)
          A_MASK:  en_mask  <= wbyte[4:0];
          A_RXCNT: rx_limit <= wbyte[3:0];
          A_ALO:   alarm_lo <= shift_byte(alarm_lo, wbyte);
          A_AHI:   alarm_hi <= shift_byte(alarm_hi, wbyte);
          default: ;
        endcase
      end
    end
  end

  // R3: a data frame while unlocked leaves the code alone
  assert_dac_held_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_cfg && unlocked) |=> $stable(dac_reg));
  // R2: the enable register ignores writes while locked
  assert_mask_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_cfg && !unlocked) |=> $stable(en_mask));
  // R4: a frame that is not a set command clears the power-on error
  assert_frame_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !cmd_set && !soft_rst) |=> !por_err);
  // R5: a soft reset leaves the block locked with the power-on error set
  assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!unlocked && por_err));
endmodule

// File: rtl/cfgflt_fault.sv
module cfgflt_fault
  import cfgflt_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int TIMEOUT_MS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              frm_valid,
  input  logic              sym_ok,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              loop_in,
  input  logic              alarm_hi_sel,
  input  logic [4:0]        en_mask,
  input  logic              por_err,
  input  logic [CODE_W-1:0] dac_reg,
  input  logic [CODE_W-1:0] alarm_lo,
  input  logic [CODE_W-1:0] alarm_hi,
  output logic [CODE_W-1:0] dac_code,
  output logic              err_n
);
  logic chan_exp, loop_exp;
  logic loop_flt, par_flt, frm_flt;
  logic loop_rep, chan_rep, par_rep, frm_rep, band_rep;

  cfgflt_timer #(.CLK_PER_MS(CLK_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_chan_tmr (
    .clk(clk), .rst_n(rst_n), .clr(sym_ok || soft_rst), .run(1'b1), .expired(chan_exp));

  cfgflt_timer #(.CLK_PER_MS(CLK_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_loop_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!loop_flt || soft_rst), .run(loop_flt), .expired(loop_exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_flt <= 1'b0;
      par_flt  <= 1'b0;
      frm_flt  <= 1'b0;
    end else if (soft_rst) begin
      loop_flt <= 1'b0;
      par_flt  <= 1'b0;
      frm_flt  <= 1'b0;
    end else begin
      if (loop_flt && loop_exp) loop_flt <= 1'b0;
      else if (loop_in)         loop_flt <= 1'b1;
      if (par_err)        par_flt <= 1'b1;
      else if (frm_valid) par_flt <= 1'b0;
      if (frm_err)        frm_flt <= 1'b1;
      else if (frm_valid) frm_flt <= 1'b0;
    end
  end

  assign loop_rep = loop_flt & en_mask[0];
  assign chan_rep = chan_exp & en_mask[1];
  assign par_rep  = par_flt  & en_mask[2];
  assign frm_rep  = frm_flt  & en_mask[3];
  assign band_rep = chan_rep | par_rep | frm_rep | por_err;

  always_comb begin
    if (loop_rep)      dac_code = alarm_lo;
    else if (band_rep) dac_code = alarm_hi_sel ? alarm_hi : alarm_lo;
    else               dac_code = dac_reg;
  end
  assign err_n = ~(loop_rep | band_rep);

  // R8: a reported loop fault drives the low alarm whatever the band pin is
  assert_loop_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_rep |-> (dac_code == alarm_lo));
  // R9: any reported band fault pulls the flag
  assert_flag_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rep || par_rep || frm_rep) |-> !err_n);
  // R7: a valid symbol ends channel inactivity
  assert_chan_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ok |=> !chan_exp);
  // R9: a clean frame drops a held parity fault
  assert_par_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !par_err) |=> !par_flt);
  // R10: with no fault the output code is the stored code
  assert_clean_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_n |-> (dac_code == dac_reg));
endmodule

// File: rtl/loop_cfg_fault.sv
module loop_cfg_fault
  import cfgflt_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int TIMEOUT_MS = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid,
  input  logic        frm_cfg,
  input  logic [7:0]  frm_addr,
  input  logic [15:0] frm_data,
  input  logic        sym_ok,
  input  logic        par_err,
  input  logic        frm_err,
  input  logic        loop_fault,
  input  logic        alarm_hi_sel,
  output logic [15:0] dac_code,
  output logic        err_n,
  output logic        ack_en,
  output logic [3:0]  rx_err_limit
);
  logic [CODE_W-1:0] dac_reg, alarm_lo, alarm_hi;
  logic [4:0]        en_mask;
  logic              por_err, soft_rst;

  cfgflt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_cfg(frm_cfg),
    .frm_addr(frm_addr), .frm_data(frm_data), .dac_reg(dac_reg),
    .alarm_lo(alarm_lo), .alarm_hi(alarm_hi), .en_mask(en_mask),
    .rx_limit(rx_err_limit), .por_err(por_err), .soft_rst(soft_rst));

  cfgflt_fault #(.CLK_PER_MS(CLK_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_fault (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frm_valid(frm_valid),
    .sym_ok(sym_ok), .par_err(par_err), .frm_err(frm_err), .loop_in(loop_fault),
    .alarm_hi_sel(alarm_hi_sel), .en_mask(en_mask), .por_err(por_err),
    .dac_reg(dac_reg), .alarm_lo(alarm_lo), .alarm_hi(alarm_hi),
    .dac_code(dac_code), .err_n(err_n));

  assign ack_en = en_mask[4];

  // R6: acknowledge enable only moves on a configuration frame
  assert_ack_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && frm_cfg) |=> $stable(ack_en));
endmodule

// File: tb/loop_cfg_fault_bench.sv
module loop_cfg_fault_bench;
  localparam int CPM = 4;
  localparam int TMO = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0, frm_cfg = 1'b0;
  logic [7:0] frm_addr = '0;
  logic [15:0] frm_data = '0;
  logic sym_ok = 1'b1, par_err = 1'b0, frm_err = 1'b0, loop_fault = 1'b0, alarm_hi_sel = 1'b0;
  logic [15:0] dac_code;
  logic err_n, ack_en;
  logic [3:0] rx_err_limit;

  int total = 0, bad = 0;
  bit finished = 0;

  // expected defaults from the 24 mA full scale
  localparam logic [15:0] LO_DEF = 16'((3375 * 65536) / 24000);
  localparam logic [15:0] HI_DEF = 16'((21750 * 65536) / 24000);

  always #2.5 clk = ~clk;

  loop_cfg_fault #(.CLK_PER_MS(CPM), .TIMEOUT_MS(TMO)) u_loop_cfg_fault (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_cfg(frm_cfg),
    .frm_addr(frm_addr), .frm_data(frm_data), .sym_ok(sym_ok), .par_err(par_err),
    .frm_err(frm_err), .loop_fault(loop_fault), .alarm_hi_sel(alarm_hi_sel),
    .dac_code(dac_code), .err_n(err_n), .ack_en(ack_en), .rx_err_limit(rx_err_limit));

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic send(input logic cfg, input logic [7:0] a, input logic [15:0] d);
    frm_cfg = cfg; frm_addr = a; frm_data = d; frm_valid = 1'b1;
    @(posedge clk); #1 frm_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_par();
    par_err = 1'b1; @(posedge clk); #1 par_err = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_frm();
    frm_err = 1'b1; @(posedge clk); #1 frm_err = 1'b0; @(negedge clk);
  endtask

  task automatic set_mask(input logic [7:0] m);
    send(1'b1, 8'h00, 16'h0095);
    send(1'b1, 8'h02, {8'h00, m});
    send(1'b1, 8'h00, 16'h0000);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "err_n", err_n, 0);
    chk("R1", "ack_en", ack_en, 1);
    chk("R1", "rx limit", rx_err_limit, 8);
    chk("R1", "low band code", dac_code, LO_DEF);
    alarm_hi_sel = 1'b1; #1;
    chk("R1", "high band code", dac_code, HI_DEF);
    alarm_hi_sel = 1'b0;
    // R3 R4: data frame while locked, first frame clears power-on error
    send(1'b0, 8'h00, 16'h1234);
    chk("R3", "code loaded", dac_code, 16'h1234);
    chk("R4", "frame clears error", err_n, 1);
    // R2: locked config writes ignored
    send(1'b1, 8'h02, 16'h0000);
    chk("R2", "mask locked", ack_en, 1);
    send(1'b1, 8'h03, 16'h0003);
    chk("R2", "limit locked", rx_err_limit, 8);
    // unlock, R6 R12
    send(1'b1, 8'h00, 16'h0095);
    send(1'b1, 8'h02, 16'h000F);
    chk("R6", "ack enable off", ack_en, 0);
    send(1'b1, 8'h02, 16'h001F);
    chk("R6", "ack enable on", ack_en, 1);
    send(1'b1, 8'h03, 16'h00F5);
    chk("R12", "limit low nibble", rx_err_limit, 5);
    send(1'b1, 8'h06, 16'h0000);
    send(1'b1, 8'h07, 16'h0000);
    chk("R12", "undefined addr ack", ack_en, 1);
    chk("R12", "undefined addr limit", rx_err_limit, 5);
    // R3: data ignored while unlocked
    send(1'b0, 8'h00, 16'hAAAA);
    chk("R3", "code held open", dac_code, 16'h1234);
    // R4 command set / clear
    send(1'b1, 8'h01, 16'h0008);
    chk("R4", "cmd set flag", err_n, 0);
    chk("R4", "cmd set code", dac_code, LO_DEF);
    send(1'b1, 8'h01, 16'h0010);
    chk("R4", "cmd clear flag", err_n, 1);
    // R11 byte pairs
    send(1'b1, 8'h04, 16'h0030);
    send(1'b1, 8'h04, 16'h0001);
    send(1'b1, 8'h05, 16'h00C0);
    send(1'b1, 8'h05, 16'h0002);
    send(1'b1, 8'h01, 16'h0008);
    chk("R11", "low alarm pair", dac_code, 16'h3001);
    alarm_hi_sel = 1'b1; #1;
    chk("R11", "high alarm pair", dac_code, 16'hC002);
    alarm_hi_sel = 1'b0;
    send(1'b1, 8'h01, 16'h0010);
    chk("R10", "back to last code", dac_code, 16'h1234);
    // R2: other value locks
    send(1'b1, 8'h00, 16'h0055);
    send(1'b1, 8'h02, 16'h0000);
    chk("R2", "relocked mask", ack_en, 1);
    send(1'b0, 8'h00, 16'h4444);
    chk("R3", "code after relock", dac_code, 16'h4444);
    // R9 parity / framing
    pulse_par();
    chk("R9", "parity flag", err_n, 0);
    chk("R9", "parity low band", dac_code, 16'h3001);
    alarm_hi_sel = 1'b1; #1;
    chk("R9", "parity high band", dac_code, 16'hC002);
    alarm_hi_sel = 1'b0;
    send(1'b0, 8'h00, 16'h4444);
    chk("R9", "parity cleared by frame", err_n, 1);
    pulse_frm();
    chk("R9", "framing flag", err_n, 0);
    send(1'b0, 8'h00, 16'h4444);
    chk("R10", "framing cleared code", dac_code, 16'h4444);
    // R6 masked parity and framing
    set_mask(8'h1B);
    pulse_par();
    chk("R6", "parity masked flag", err_n, 1);
    chk("R6", "parity masked code", dac_code, 16'h4444);
    send(1'b0, 8'h00, 16'h4444);
    set_mask(8'h17);
    pulse_frm();
    chk("R6", "framing masked flag", err_n, 1);
    send(1'b0, 8'h00, 16'h4444);
    set_mask(8'h1F);
    // R7 channel timeout edge
    @(posedge clk); #1 sym_ok = 1'b0;
    repeat (CPM*TMO - 1) @(posedge clk);
    @(negedge clk);
    chk("R7", "one cycle before timeout", err_n, 1);
    @(posedge clk); @(negedge clk);
    chk("R7", "at timeout", err_n, 0);
    chk("R9", "channel low band", dac_code, 16'h3001);
    sym_ok = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7", "symbol clears", err_n, 1);
    chk("R10", "channel cleared code", dac_code, 16'h4444);
    // R6 masked channel
    set_mask(8'h1D);
    @(posedge clk); #1 sym_ok = 1'b0;
    repeat (CPM*TMO + 10) @(posedge clk);
    @(negedge clk);
    chk("R6", "channel masked", err_n, 1);
    sym_ok = 1'b1;
    @(posedge clk); @(negedge clk);
    set_mask(8'h1F);
    // R8 loop fault
    alarm_hi_sel = 1'b1;
    @(posedge clk); #1 loop_fault = 1'b1;
    @(posedge clk); #1 loop_fault = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8", "loop forces low", dac_code, 16'h3001);
    chk("R8", "loop flag", err_n, 0);
    repeat (CPM*TMO + 10) @(posedge clk);
    @(negedge clk);
    chk("R8", "loop self clears", dac_code, 16'h4444);
    chk("R8", "loop flag clears", err_n, 1);
    alarm_hi_sel = 1'b0;
    set_mask(8'h1E);
    @(posedge clk); #1 loop_fault = 1'b1;
    @(posedge clk); #1 loop_fault = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6", "loop masked flag", err_n, 1);
    chk("R6", "loop masked code", dac_code, 16'h4444);
    repeat (CPM*TMO + 10) @(posedge clk);
    @(negedge clk);
    // R5 soft reset
    send(1'b1, 8'h00, 16'h0095);
    send(1'b1, 8'h03, 16'h0002);
    chk("R12", "limit written", rx_err_limit, 2);
    send(1'b1, 8'h01, 16'h0001);
    chk("R5", "limit restored", rx_err_limit, 8);
    chk("R5", "ack restored", ack_en, 1);
    chk("R5", "power-on error back", err_n, 0);
    chk("R5", "alarm default back", dac_code, LO_DEF);
    send(1'b0, 8'h00, 16'h0100);
    chk("R5", "locked after reset", dac_code, 16'h0100);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule